// File: doc/BRIEF.md
# Key-Protected Slow Clock Selector

This block picks the low-speed time base for a real-time clock. It has two clock-enable inputs in one fast clock domain. One comes from an internal RC oscillator, which is divided by a programmable amount. The other comes from an external 32 kHz crystal, which passes through undivided. The block turns the chosen source into a one-cycle slow tick enable. A gated copy of that tick drives an output pin.

Software programs the block through a simple register bus. The write strobe, address and write data are sampled on the rising clock edge. Read data is a combinational function of the address. There are three registers:
- The source-select register accepts a write only when the upper half of the write data holds a fixed unlock key. This stops a stray write from switching the clock source.
- The divider register needs no key.
- The output-gate register needs no key.

Top module: `slowclk_sel`

## Requirements
- R1: After reset the source is internal, the divide value is 0 and the output gate is off. Every register reads as zero, and `slowTick` and `slowTickOut` are low until ticks arrive.
- R2: A write to address 0x00 updates the source select from data bit 0 only when data bits 31:16 equal 0x16AA. With any other key value the source select is unchanged.
- R3: A read of address 0x00 returns the source select in bit 0 (1 = external crystal, 0 = internal RC). Bits 31:1, including the key field, read as zero.
- R4: Address 0x08 holds a 5-bit divide value N in bits 4:0. It is written without a key. Reads return N in bits 4:0, with bits 31:5 zero.
- R5: With the internal source selected, `slowTick` pulses once for every N+1 internal enables. The pulse comes one cycle after the enable that completes the count.
- R6: With the external source selected, `slowTick` is high exactly one cycle after each external enable. Internal enables have no effect on it.
- R7: Bit 0 of address 0x60 gates the output. When it is 1, `slowTickOut` equals `slowTick`. When it is 0, `slowTickOut` stays low. Reads return the gate bit in bit 0.
- R8: A write to 0x08, or an accepted write to 0x00, clears the divider count. No internal tick comes from that cycle. The next internal tick follows N+1 further internal enables.
- R9: Writes to any other address change no register, and reads of any other address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the whole block |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| intOscTick | input | 1 | Enable pulse from the internal RC oscillator |
| extXtalTick | input | 1 | Enable pulse from the external crystal |
| slowTick | output | 1 | One-cycle tick at the selected slow rate |
| slowTickOut | output | 1 | Gated copy of `slowTick` for the output pin |

## Verification
The assertions check several behaviours on every cycle:
- a write with a wrong key leaves the source select unchanged;
- the unused read bits stay zero;
- an external enable in crystal mode produces a tick on the next cycle;
- no internal tick appears without an enable, or on a restart cycle;
- the closed gate holds the output low.

Some behaviours depend on history, so only the bench scenarios can show them:
- the exact N+1 spacing of internal ticks, with the small, zero and largest divide values;
- the restart of the count after a prescaler rewrite in the middle of a count;
- read-back after writes that are accepted and writes that are refused.

The reference model tracks these and is compared on every clock.

// File: rtl/slowclk_pkg.sv
package slowclk_pkg;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int PRESC_W = 5;
  localparam int KEY_W   = 16;

  localparam logic [KEY_W-1:0]  UNLOCK_KEY = 16'h16AA;
  localparam logic [ADDR_W-1:0] OFF_SRC    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_DIV    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_GATE   = 8'h60;

  typedef struct packed {
    logic               restartDiv;
    logic               useExt;
    logic [PRESC_W-1:0] divN;
    logic               gateOn;
  } ctlStrobes_t;

endpackage

// File: rtl/slowclk_ctrl.sv
module slowclk_ctrl
  import slowclk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PRESC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  output ctlStrobes_t   stb
);

  localparam int KEY_LO = DW - KEY_W;

  logic          srcExtQ;
  logic [PW-1:0] divNQ;
  logic          gateQ;

  logic hitSrc, hitDiv, hitGate, keyOk;

  assign hitSrc  = (busAddr == AW'(OFF_SRC));
  assign hitDiv  = (busAddr == AW'(OFF_DIV));
  assign hitGate = (busAddr == AW'(OFF_GATE));
  assign keyOk   = (busWdata[DW-1:KEY_LO] == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcExtQ <= 1'b0;
      divNQ   <= '0;
      gateQ   <= 1'b0;
    end else if (busWr) begin
      if (hitSrc && keyOk) srcExtQ <= busWdata[0];
      if (hitDiv)          divNQ   <= busWdata[PW-1:0];
      if (hitGate)         gateQ   <= busWdata[0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitSrc)       busRdata[0]      = srcExtQ;
    else if (hitDiv)  busRdata[PW-1:0] = divNQ;
    else if (hitGate) busRdata[0]      = gateQ;
  end

  always_comb begin
    stb.restartDiv = busWr && (hitDiv || (hitSrc && keyOk));
    stb.useExt     = srcExtQ;
    stb.divN       = divNQ;
    stb.gateOn     = gateQ;
  end

endmodule

// File: rtl/slowclk_datapath.sv
module slowclk_datapath
  import slowclk_pkg::*;
#(
  parameter int PW = PRESC_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic        intOscTick,
  input  logic        extXtalTick,
  output logic        slowTick,
  output logic        slowTickOut
);

  logic [PW-1:0] divCnt;
  logic          countDone;
  logic          tickNext;

  assign countDone = (divCnt == stb.divN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (stb.restartDiv) begin
      divCnt <= '0;
    end else if (intOscTick) begin
      divCnt <= countDone ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    if (stb.useExt) tickNext = extXtalTick;
    else            tickNext = intOscTick && !stb.restartDiv && countDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) slowTick <= 1'b0;
    else       slowTick <= tickNext;
  end

  assign slowTickOut = slowTick && stb.gateOn;

endmodule

// File: rtl/slowclk_sel.sv
module slowclk_sel
  import slowclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              intOscTick,
  input  logic              extXtalTick,
  output logic              slowTick,
  output logic              slowTickOut
);

  ctlStrobes_t stb;

  slowclk_ctrl #(.AW(ADDR_W), .DW(DATA_W), .PW(PRESC_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .stb      (stb)
  );

  slowclk_datapath #(.PW(PRESC_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .intOscTick  (intOscTick),
    .extXtalTick (extXtalTick),
    .slowTick    (slowTick),
    .slowTickOut (slowTickOut)
  );

endmodule

// File: rtl/slowclk_sel_chk.sv
module slowclk_sel_chk
  import slowclk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              intOscTick,
  input logic              extXtalTick,
  input logic              slowTick,
  input logic              slowTickOut,
  input logic              useExt,
  input logic              gateOn,
  input logic              restartDiv
);

  a_r2_bad_key_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == OFF_SRC && busWdata[DATA_W-1:DATA_W-KEY_W] != UNLOCK_KEY)
      |=> $stable(useExt));

  a_r3_src_read_clean: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_SRC) |-> (busRdata[DATA_W-1:1] == '0));

  a_r4_div_read_clean: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == OFF_DIV) |-> (busRdata[DATA_W-1:PRESC_W] == '0));

  a_r6_ext_follows: assert property (@(posedge clk) disable iff (!rstN)
    (useExt && extXtalTick) |=> slowTick);

  a_r5_no_int_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!useExt && !intOscTick) |=> !slowTick);

  a_r8_restart_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!useExt && restartDiv) |=> !slowTick);

  a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rstN)
    !gateOn |-> !slowTickOut);

endmodule

bind slowclk_sel slowclk_sel_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .intOscTick  (intOscTick),
  .extXtalTick (extXtalTick),
  .slowTick    (slowTick),
  .slowTickOut (slowTickOut),
  .useExt      (stb.useExt),
  .gateOn      (stb.gateOn),
  .restartDiv  (stb.restartDiv)
);

// File: tb/slowclk_sel_tb.sv
`timescale 1ns/1ps
module slowclk_sel_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        intOscTick = 1'b0;
  logic        extXtalTick = 1'b0;
  logic        slowTick;
  logic        slowTickOut;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string curReq = "R1";
  bit    done = 0;

  always #5 clk = ~clk;

  slowclk_sel dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .intOscTick(intOscTick),
    .extXtalTick(extXtalTick), .slowTick(slowTick), .slowTickOut(slowTickOut)
  );

  // behavioural reference model
  int mSel = 0, mN = 0, mGate = 0, mCnt = 0, mTick = 0;

  function automatic int modelRead(input logic [7:0] a);
    if (a == 8'h00) return mSel;
    if (a == 8'h08) return mN;
    if (a == 8'h60) return mGate;
    return 0;
  endfunction

  always @(posedge clk) begin
    int  nextTick;
    bit  keyGood, restart;
    if (!rstN) begin
      mSel = 0; mN = 0; mGate = 0; mCnt = 0; mTick = 0;
    end else begin
      keyGood = (busWdata[31:16] == 16'h16AA);
      restart = busWr && (busAddr == 8'h08 || (busAddr == 8'h00 && keyGood));
      if (mSel != 0) nextTick = extXtalTick ? 1 : 0;
      else nextTick = (intOscTick && !restart && mCnt == mN) ? 1 : 0;
      if (restart) mCnt = 0;
      else if (intOscTick) mCnt = (mCnt == mN) ? 0 : mCnt + 1;
      if (busWr) begin
        if (busAddr == 8'h00 && keyGood) mSel = busWdata[0];
        if (busAddr == 8'h08) mN = busWdata[4:0];
        if (busAddr == 8'h60) mGate = busWdata[0];
      end
      mTick = nextTick;
    end
    cycles++;
  end

  task automatic check(input string req, input longint act, input longint exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, slowTick, mTick, "slowTick");
      check(curReq, slowTickOut, (mTick != 0 && mGate != 0) ? 1 : 0, "slowTickOut");
      check(curReq, busRdata, modelRead(busAddr), "busRdata");
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    cyc();
    busWr = 1'b0; busWdata = 32'h0;
  endtask

  task automatic regRead(input logic [7:0] a, input longint exp, input string req);
    busAddr = a;
    #2;
    check(req, busRdata, exp, "read");
    cyc();
  endtask

  // n cycles, internal enable every iPer cycles, external every ePer (0 = none)
  task automatic drive(input int n, input int iPer, input int ePer);
    for (int k = 0; k < n; k++) begin
      intOscTick  = (iPer != 0) && (k % iPer == 0);
      extXtalTick = (ePer != 0) && (k % ePer == 0);
      cyc();
    end
    intOscTick = 1'b0; extXtalTick = 1'b0;
  endtask

  task automatic countTicks(input int n, input int iPer, input int ePer, input int exp, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      intOscTick  = (iPer != 0) && (k % iPer == 0);
      extXtalTick = (ePer != 0) && (k % ePer == 0);
      cyc();
      if (slowTick) seen++;
    end
    intOscTick = 1'b0; extXtalTick = 1'b0;
    cyc();
    if (slowTick) seen++;
    check(req, seen, exp, "tick count");
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    // R1 reset state
    curReq = "R1";
    check("R1", slowTick, 0, "slowTick after reset");
    regRead(8'h00, 0, "R1");
    regRead(8'h08, 0, "R1");
    regRead(8'h60, 0, "R1");
    drive(4, 1, 0);
    // R5 divide by 1 with N=0: every internal enable ticks
    curReq = "R5";
    countTicks(6, 1, 0, 6, "R5");
    // R2 bad key refused
    curReq = "R2";
    regWrite(8'h00, 32'h16AB_0001);
    regRead(8'h00, 0, "R2");
    regWrite(8'h00, 32'h0000_0001);
    regRead(8'h00, 0, "R2");
    regWrite(8'h00, 32'h16AA_0001);
    // R3 key bits read as zero
    curReq = "R3";
    regRead(8'h00, 1, "R3");
    // R6 external mode, internal enables ignored
    curReq = "R6";
    countTicks(12, 1, 3, 4, "R6");
    countTicks(10, 2, 0, 0, "R6");
    // R2 bad key cannot return to internal
    curReq = "R2";
    regWrite(8'h00, 32'h0000_0000);
    regRead(8'h00, 1, "R2");
    regWrite(8'h00, 32'h16AA_FFFE);
    regRead(8'h00, 0, "R2");
    // R4 prescaler write and readback masking
    curReq = "R4";
    regWrite(8'h08, 32'hFFFF_FFE3);
    regRead(8'h08, 32'h03, "R4");
    // R5 divide by 4
    curReq = "R5";
    countTicks(16, 1, 0, 4, "R5");
    countTicks(24, 2, 5, 3, "R5");
    // R8 restart mid-count
    curReq = "R8";
    drive(2, 1, 0);
    regWrite(8'h08, 32'h0000_0002);
    countTicks(3, 1, 0, 1, "R8");
    drive(1, 1, 0);
    intOscTick = 1'b1;
    regWrite(8'h08, 32'h0000_0002);
    intOscTick = 1'b0;
    check("R8", slowTick, 0, "no tick on restart");
    countTicks(2, 1, 0, 0, "R8");
    // R7 gate
    curReq = "R7";
    regWrite(8'h60, 32'h0000_0001);
    regRead(8'h60, 1, "R7");
    drive(12, 1, 0);
    regWrite(8'h60, 32'h0000_0000);
    drive(8, 1, 0);
    // R9 unmapped addresses
    curReq = "R9";
    regWrite(8'h04, 32'h16AA_FFFF);
    regWrite(8'h0C, 32'hFFFF_FFFF);
    regRead(8'h04, 0, "R9");
    regRead(8'h00, 0, "R9");
    regRead(8'h08, 2, "R9");
    regRead(8'h60, 0, "R9");
    // R5 largest divide value
    curReq = "R5";
    regWrite(8'h08, 32'h0000_001F);
    countTicks(96, 1, 0, 3, "R5");
    finishRun();
  end

endmodule